// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block moves the register context of an 8-bit processor core between the core and a byte-wide stack in memory. It handles two kinds of work. For an entry sequence it writes the context to the stack and then reads a 16-bit handler address from a vector slot. For a return sequence it reads the context back from the stack. Entry sequences come from the block's own reset, from a non-maskable interrupt line, from a maskable interrupt line and from a software-interrupt request. Return sequences come from a return request. A wait request writes the context to the stack ahead of time and then parks the block until an interrupt arrives. At that point only the vector is read.

The core presents a snapshot of its program counter, index register, two accumulators, condition-code byte and stack pointer. At the end of each sequence the block presents the new values on its context outputs, together with a one-cycle done strobe and a code that names the sequence. Instruction decode and arithmetic stay in the core. The core holds its software request (software interrupt, wait, return) until it sees done, or until it sees wait_idle in the case of the wait request. It takes the context outputs while done is high and updates its snapshot from them.

Memory traffic uses a valid/ready handshake. A beat is one access. It completes in a cycle where mem_valid and mem_ready are both high. While mem_ready is low the block holds the address, the direction and the write data unchanged. On a read beat, mem_rdata is taken in the cycle of the handshake.

Top module: `irqseq_top`

## Requirements
- R1: After rst_n is released the block makes no writes. It reads FFFE and then FFFF, and then pulses done with done_op=1. At that point ctx_pc={byte at FFFE, byte at FFFF}, ctx_ccr=8'hD0 and ctx_sp equals snap_sp.
- R2: An entry for the non-maskable interrupt, the maskable interrupt or the software interrupt writes seven bytes to addresses SP, SP-1, ..., SP-6. SP is snap_sp when the request is accepted. The byte order is PC low, PC high, X low, X high, A, B, then the condition-code byte with bits 7:6 forced to 1. At done, ctx_sp=SP-7.
- R3: Each vector is read high byte first from the even address, then low byte from the odd address. The vector pairs are FFF8 for the maskable interrupt, FFFA for the software interrupt, FFFC for the non-maskable interrupt and FFFE for reset. ctx_pc is the 16-bit value read.
- R4: After any entry, ctx_ccr has bit 4 (interrupt mask) set and bits 7:6 set. The other bits are those of the stacked byte. ctx_x, ctx_a and ctx_b equal the snapshot.
- R5: The non-maskable interrupt is taken on a falling edge of nmi_n. Holding the line low does not start another sequence. An edge that arrives during a busy sequence is remembered and serviced once that sequence finishes.
- R6: The maskable interrupt is level-sensitive (irq_n low). It is ignored while snap_ccr bit 4 is 1 and is taken once that bit is 0.
- R7: When requests arrive together the order is reset, then non-maskable, then maskable, then software interrupt, then wait, then return.
- R8: A return reads SP+1 through SP+7 in the order condition-code, B, A, X high, X low, PC high, PC low. It restores every register, with ctx_ccr being the byte read with bits 7:6 forced to 1. It sets ctx_sp=SP+7 and pulses done with done_op=6.
- R9: A wait request first writes the stack exactly as in R2. It then raises wait_idle and makes no bus access until a non-maskable edge or an unmasked maskable interrupt arrives. It then reads that vector without writing again, and done_op names the interrupt.
- R10: While mem_valid is high and mem_ready is low, mem_valid, mem_addr, mem_write and mem_wdata are held. Every stall pattern gives the same result as a memory that is always ready.
- R11: done is a single-cycle pulse in the cycle after the handshake of the last beat. The codes are 1 reset, 2 non-maskable, 3 maskable, 4 software interrupt and 6 return. The ctx outputs are valid while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; release starts the reset vector fetch |
| nmi_n | input | 1 | Non-maskable interrupt, falling-edge sensitive |
| irq_n | input | 1 | Maskable interrupt, active-low level |
| swi_req | input | 1 | Software-interrupt request, held until done |
| wai_req | input | 1 | Wait request, held until wait_idle |
| rti_req | input | 1 | Return request, held until done |
| snap_pc | input | 16 | Core program counter |
| snap_x | input | 16 | Core index register |
| snap_a | input | 8 | Core accumulator A |
| snap_b | input | 8 | Core accumulator B |
| snap_ccr | input | 8 | Core condition-code byte, bit 4 is the interrupt mask |
| snap_sp | input | 16 | Core stack pointer |
| mem_valid | output | 1 | Beat request |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_write | output | 1 | 1 for write beat, 0 for read beat |
| mem_addr | output | 16 | Beat address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the handshake cycle |
| done | output | 1 | Sequence finished, one cycle |
| done_op | output | 3 | Code of the finished sequence |
| wait_idle | output | 1 | Context stacked, waiting for an interrupt |
| ctx_pc | output | 16 | Resulting program counter |
| ctx_x | output | 16 | Resulting index register |
| ctx_a | output | 8 | Resulting accumulator A |
| ctx_b | output | 8 | Resulting accumulator B |
| ctx_ccr | output | 8 | Resulting condition-code byte |
| ctx_sp | output | 16 | Resulting stack pointer |

## Verification
The bench first checks the byte order and the addresses on the stack for entry and return sequences, once with a memory that is always ready and once with a memory that stalls. A swapped byte or an off-by-one stack pointer shows up as a wrong log entry or a wrong ctx_sp. A non-maskable edge is dropped during a software-interrupt sequence. A design that only samples the edge while idle would lose that interrupt. Holding nmi_n low after service would expose a level-triggered design, which would retrigger. Simultaneous requests check the priority order. A raised mask with irq_n low checks that masking works, since a design that ignores the mask would start stacking. A wait that is woken by the maskable line must read only the vector. A design that stacks a second time would show extra writes and a stack pointer seven bytes too low.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 16;
  localparam int CTX_BYTES = 7;
  localparam int IDX_W     = $clog2(CTX_BYTES + 1);
  localparam int CCR_I     = 4;
  localparam logic [BYTE_W-1:0] CCR_PAD   = 8'hC0;
  localparam logic [BYTE_W-1:0] CCR_IMASK = 8'h01 << CCR_I;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_RESET = 3'd1,
    OP_NMI   = 3'd2,
    OP_IRQ   = 3'd3,
    OP_SWI   = 3'd4,
    OP_WAI   = 3'd5,
    OP_RTI   = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH, ST_WAIT, ST_VHI, ST_VLO, ST_PULL, ST_DONE
  } st_e;

  typedef struct packed {
    logic [WORD_W-1:0] pc;
    logic [WORD_W-1:0] x;
    logic [BYTE_W-1:0] a;
    logic [BYTE_W-1:0] b;
    logic [BYTE_W-1:0] ccr;
  } ctx_t;

  // Even address of the vector pair for a sequence kind.
  function automatic logic [WORD_W-1:0] vec_addr(input op_e op, input logic [WORD_W-1:0] base);
    case (op)
      OP_IRQ:  return base;
      OP_SWI:  return base + WORD_W'(2);
      OP_NMI:  return base + WORD_W'(4);
      default: return base + WORD_W'(6);
    endcase
  endfunction
endpackage

// File: rtl/irqseq_arb.sv
module irqseq_arb
  import irqseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic irq_n,
  input  logic irq_mask,
  input  logic swi_req,
  input  logic wai_req,
  input  logic rti_req,
  input  logic only_int,
  input  logic take,
  output op_e  pick
);
  logic nmi_q;
  logic nmi_pend;
  logic rst_pend;
  logic nmi_edge;

  assign nmi_edge = nmi_q & ~nmi_n;

  always_comb begin
    if (rst_pend)                      pick = OP_RESET;
    else if (nmi_pend || nmi_edge)     pick = OP_NMI;
    else if (!irq_n && !irq_mask)      pick = OP_IRQ;
    else if (only_int)                 pick = OP_NONE;
    else if (swi_req)                  pick = OP_SWI;
    else if (wai_req)                  pick = OP_WAI;
    else if (rti_req)                  pick = OP_RTI;
    else                               pick = OP_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q    <= 1'b1;
      nmi_pend <= 1'b0;
      rst_pend <= 1'b1;
    end else begin
      nmi_q    <= nmi_n;
      nmi_pend <= (nmi_pend | nmi_edge) & ~(take && pick == OP_NMI);
      rst_pend <= rst_pend & ~(take && pick == OP_RESET);
    end
  end

  AST_NMI_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_edge && !(take && pick == OP_NMI)) |=> nmi_pend); // R5
endmodule

// File: rtl/irqseq_fsm.sv
module irqseq_fsm
  import irqseq_pkg::*;
#(
  parameter logic [WORD_W-1:0] VEC_BASE = 16'hFFF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               pick,
  input  logic [WORD_W-1:0] snap_sp,
  input  logic              mem_ready,
  output logic              take,
  output logic              capture,
  output logic              hs,
  output st_e               st,
  output op_e               op,
  output logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] sp,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [WORD_W-1:0] mem_addr
);
  logic last;
  logic [WORD_W-1:0] vec;

  assign take      = (st == ST_IDLE || st == ST_WAIT) && pick != OP_NONE;
  assign capture   = take && st == ST_IDLE;
  assign mem_valid = st == ST_PUSH || st == ST_PULL || st == ST_VHI || st == ST_VLO;
  assign mem_write = st == ST_PUSH;
  assign hs        = mem_valid && mem_ready;
  assign last      = idx == IDX_W'(CTX_BYTES - 1);
  assign vec       = vec_addr(op, VEC_BASE);

  always_comb begin
    case (st)
      ST_PUSH: mem_addr = sp;
      ST_PULL: mem_addr = sp + WORD_W'(1);
      ST_VHI:  mem_addr = vec;
      ST_VLO:  mem_addr = vec | WORD_W'(1);
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      op  <= OP_NONE;
      idx <= '0;
      sp  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (take) begin
          op  <= pick;
          sp  <= snap_sp;
          idx <= '0;
          case (pick)
            OP_RESET: st <= ST_VHI;
            OP_RTI:   st <= ST_PULL;
            default:  st <= ST_PUSH;
          endcase
        end
        ST_PUSH: if (hs) begin
          sp  <= sp - WORD_W'(1);
          idx <= idx + IDX_W'(1);
          if (last) st <= (op == OP_WAI) ? ST_WAIT : ST_VHI;
        end
        ST_WAIT: if (take) begin
          op <= pick;
          st <= ST_VHI;
        end
        ST_VHI: if (hs) st <= ST_VLO;
        ST_VLO: if (hs) st <= ST_DONE;
        ST_PULL: if (hs) begin
          sp  <= sp + WORD_W'(1);
          idx <= idx + IDX_W'(1);
          if (last) st <= ST_DONE;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_WAIT_NO_WRITE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && take) |=> (mem_valid && !mem_write)); // R9
endmodule

// File: rtl/irqseq_ctx.sv
module irqseq_ctx
  import irqseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  ctx_t              snap,
  input  st_e               st,
  input  op_e               op,
  input  logic [IDX_W-1:0]  idx,
  input  logic              hs,
  input  logic [BYTE_W-1:0] rdata,
  output ctx_t              ctx,
  output logic [BYTE_W-1:0] wdata
);
  logic [IDX_W-1:0] pull_slot;

  // Slot k is the k-th byte written on entry; a return walks them backwards.
  function automatic logic [BYTE_W-1:0] slot_byte(input ctx_t c, input logic [IDX_W-1:0] k);
    case (k)
      IDX_W'(0): return c.pc[7:0];
      IDX_W'(1): return c.pc[15:8];
      IDX_W'(2): return c.x[7:0];
      IDX_W'(3): return c.x[15:8];
      IDX_W'(4): return c.a;
      IDX_W'(5): return c.b;
      default:   return c.ccr;
    endcase
  endfunction

  assign wdata     = slot_byte(ctx, idx);
  assign pull_slot = IDX_W'(CTX_BYTES - 1) - idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx <= '0;
    end else if (capture) begin
      ctx     <= snap;
      ctx.ccr <= snap.ccr | CCR_PAD;
    end else if (hs) begin
      case (st)
        ST_PULL: begin
          case (pull_slot)
            IDX_W'(0): ctx.pc[7:0]  <= rdata;
            IDX_W'(1): ctx.pc[15:8] <= rdata;
            IDX_W'(2): ctx.x[7:0]   <= rdata;
            IDX_W'(3): ctx.x[15:8]  <= rdata;
            IDX_W'(4): ctx.a        <= rdata;
            IDX_W'(5): ctx.b        <= rdata;
            default:   ctx.ccr      <= rdata | CCR_PAD;
          endcase
        end
        ST_VHI: ctx.pc[15:8] <= rdata;
        ST_VLO: begin
          ctx.pc[7:0] <= rdata;
          ctx.ccr     <= (op == OP_RESET) ? (CCR_PAD | CCR_IMASK)
                                          : (ctx.ccr | CCR_PAD | CCR_IMASK);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irqseq_top.sv
module irqseq_top
  import irqseq_pkg::*;
#(
  parameter logic [15:0] VEC_BASE = 16'hFFF8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nmi_n,
  input  logic        irq_n,
  input  logic        swi_req,
  input  logic        wai_req,
  input  logic        rti_req,
  input  logic [15:0] snap_pc,
  input  logic [15:0] snap_x,
  input  logic [7:0]  snap_a,
  input  logic [7:0]  snap_b,
  input  logic [7:0]  snap_ccr,
  input  logic [15:0] snap_sp,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_write,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        done,
  output logic [2:0]  done_op,
  output logic        wait_idle,
  output logic [15:0] ctx_pc,
  output logic [15:0] ctx_x,
  output logic [7:0]  ctx_a,
  output logic [7:0]  ctx_b,
  output logic [7:0]  ctx_ccr,
  output logic [15:0] ctx_sp
);
  op_e              pick;
  op_e              op;
  st_e              st;
  logic             take;
  logic             capture;
  logic             hs;
  logic [IDX_W-1:0] idx;
  ctx_t             snap;
  ctx_t             ctx;

  assign snap = '{pc: snap_pc, x: snap_x, a: snap_a, b: snap_b, ccr: snap_ccr};

  irqseq_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_n    (nmi_n),
    .irq_n    (irq_n),
    .irq_mask (snap_ccr[CCR_I]),
    .swi_req  (swi_req),
    .wai_req  (wai_req),
    .rti_req  (rti_req),
    .only_int (st == ST_WAIT),
    .take     (take),
    .pick     (pick)
  );

  irqseq_fsm #(.VEC_BASE(VEC_BASE)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pick      (pick),
    .snap_sp   (snap_sp),
    .mem_ready (mem_ready),
    .take      (take),
    .capture   (capture),
    .hs        (hs),
    .st        (st),
    .op        (op),
    .idx       (idx),
    .sp        (ctx_sp),
    .mem_valid (mem_valid),
    .mem_write (mem_write),
    .mem_addr  (mem_addr)
  );

  irqseq_ctx u_ctx (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .snap    (snap),
    .st      (st),
    .op      (op),
    .idx     (idx),
    .hs      (hs),
    .rdata   (mem_rdata),
    .ctx     (ctx),
    .wdata   (mem_wdata)
  );

  assign done      = st == ST_DONE;
  assign done_op   = op;
  assign wait_idle = st == ST_WAIT;
  assign ctx_pc    = ctx.pc;
  assign ctx_x     = ctx.x;
  assign ctx_a     = ctx.a;
  assign ctx_b     = ctx.b;
  assign ctx_ccr   = ctx.ccr;

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)
                                   && $stable(mem_wdata))); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_valid && mem_ready)); // R11
  AST_ENTRY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_op != 3'd6) |-> ctx_ccr[CCR_I]); // R4
  AST_CCR_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ctx_ccr[7:6] == 2'b11)); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pick == OP_IRQ) |-> !snap_ccr[CCR_I]); // R6
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wait_idle |-> !mem_valid); // R9
endmodule

// File: tb/test_irqseq_top.sv
module test_irqseq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_n = 1'b1, irq_n = 1'b1;
  logic        swi_req = 1'b0, wai_req = 1'b0, rti_req = 1'b0;
  logic [15:0] snap_pc = '0, snap_x = '0, snap_sp = '0;
  logic [7:0]  snap_a = '0, snap_b = '0, snap_ccr = '0;
  logic        mem_valid, mem_write, mem_ready = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        done, wait_idle;
  logic [2:0]  done_op;
  logic [15:0] ctx_pc, ctx_x, ctx_sp;
  logic [7:0]  ctx_a, ctx_b, ctx_ccr;

  int checks = 0, errors = 0, cyc = 0;
  bit stall = 1'b0;
  logic [7:0]  stk [0:255];
  logic [7:0]  vrom [0:7];
  logic [15:0] wr_a [0:15];
  logic [7:0]  wr_d [0:15];
  logic [15:0] rd_a [0:15];
  int wr_n = 0, rd_n = 0;

  always #5 clk = ~clk;

  irqseq_top i_irqseq_top (.*);

  assign mem_rdata = (mem_addr[15:3] == 13'h1FFF) ? vrom[mem_addr[2:0]] : stk[mem_addr[7:0]];

  always @(negedge clk) begin
    cyc++;
    mem_ready = !stall || (cyc % 3 == 0);
  end

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (mem_write) begin
        if (wr_n < 16) begin wr_a[wr_n] = mem_addr; wr_d[wr_n] = mem_wdata; end
        wr_n++;
        stk[mem_addr[7:0]] = mem_wdata;
      end else begin
        if (rd_n < 16) rd_a[rd_n] = mem_addr;
        rd_n++;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    wr_n = 0;
    rd_n = 0;
  endtask

  task automatic wait_done(input string req);
    bit got = 1'b0;
    for (int i = 0; i < 400 && !got; i++) begin
      @(negedge clk);
      if (done) got = 1'b1;
    end
    chk(req, "done seen", got, 1'b1);
  endtask

  task automatic adopt();
    snap_pc = ctx_pc; snap_x = ctx_x; snap_a = ctx_a;
    snap_b = ctx_b; snap_ccr = ctx_ccr; snap_sp = ctx_sp;
  endtask

  task automatic chk_pushes(input string req, input logic [15:0] sp0, input logic [15:0] pc,
                            input logic [15:0] x, input logic [7:0] a, input logic [7:0] b,
                            input logic [7:0] ccr);
    logic [7:0] exp [0:6];
    exp[0] = pc[7:0]; exp[1] = pc[15:8]; exp[2] = x[7:0]; exp[3] = x[15:8];
    exp[4] = a; exp[5] = b; exp[6] = ccr | 8'hC0;
    chk(req, "write count", wr_n, 7);
    for (int k = 0; k < 7; k++) begin
      chk(req, $sformatf("push %0d addr", k), wr_a[k], sp0 - 16'(k));
      chk(req, $sformatf("push %0d data", k), wr_d[k], exp[k]);
    end
  endtask

  task automatic set_snap(input logic [15:0] pc, input logic [15:0] x, input logic [7:0] a,
                          input logic [7:0] b, input logic [7:0] ccr, input logic [15:0] sp);
    snap_pc = pc; snap_x = x; snap_a = a; snap_b = b; snap_ccr = ccr; snap_sp = sp;
  endtask

  task automatic t_reset();
    wait_done("R1");
    chk("R1", "done_op", done_op, 3'd1);
    chk("R1", "writes", wr_n, 0);
    chk("R1", "reads", rd_n, 2);
    chk("R3", "reset vec hi addr", rd_a[0], 16'hFFFE);
    chk("R3", "reset vec lo addr", rd_a[1], 16'hFFFF);
    chk("R1", "pc", ctx_pc, 16'hDEF0);
    chk("R1", "ccr", ctx_ccr, 8'hD0);
    chk("R1", "sp", ctx_sp, 16'h01F0);
  endtask

  task automatic t_swi(input bit s);
    string rq = s ? "R10" : "R2";
    stall = s;
    set_snap(16'hA1B2, 16'hC3D4, 8'hE5, 8'hF6, 8'h0B, 16'h01F0);
    clear_logs();
    swi_req = 1'b1;
    wait_done(rq);
    swi_req = 1'b0;
    chk("R11", "swi done_op", done_op, 3'd4);
    chk_pushes(rq, 16'h01F0, 16'hA1B2, 16'hC3D4, 8'hE5, 8'hF6, 8'h0B);
    chk("R3", "swi vec reads", {rd_a[0], rd_a[1]}, {16'hFFFA, 16'hFFFB});
    chk("R3", "swi pc", ctx_pc, 16'h5678);
    chk("R2", "swi sp", ctx_sp, 16'h01E9);
    chk("R4", "swi ccr", ctx_ccr, 8'hDB);
    chk("R4", "swi x/a/b", {ctx_x, ctx_a, ctx_b}, {16'hC3D4, 8'hE5, 8'hF6});
    stall = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_irq_mask();
    set_snap(16'h1000, 16'h2000, 8'h01, 8'h02, 8'h10, 16'h01F0);
    clear_logs();
    irq_n = 1'b0;
    repeat (20) @(negedge clk);
    chk("R6", "masked irq bus quiet", wr_n + rd_n, 0);
    snap_ccr = 8'h00;
    wait_done("R6");
    chk("R6", "irq done_op", done_op, 3'd3);
    chk("R3", "irq pc", ctx_pc, 16'h1234);
    chk("R3", "irq vec reads", {rd_a[0], rd_a[1]}, {16'hFFF8, 16'hFFF9});
    chk("R4", "irq ccr", ctx_ccr, 8'hD0);
    adopt();
    irq_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_nmi();
    set_snap(16'h3000, 16'h4000, 8'h03, 8'h04, 8'h10, 16'h01F0);
    clear_logs();
    nmi_n = 1'b0;
    wait_done("R5");
    chk("R5", "nmi done_op", done_op, 3'd2);
    chk("R3", "nmi pc", ctx_pc, 16'h9ABC);
    chk("R2", "nmi sp", ctx_sp, 16'h01E9);
    adopt();
    clear_logs();
    repeat (20) @(negedge clk);
    chk("R5", "held-low nmi quiet", wr_n + rd_n, 0);
    nmi_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_nmi_during_swi();
    logic [15:0] sp1;
    set_snap(16'h5555, 16'h6666, 8'h07, 8'h08, 8'h00, 16'h01F0);
    clear_logs();
    swi_req = 1'b1;
    for (int i = 0; i < 50 && wr_n < 2; i++) @(negedge clk);
    nmi_n = 1'b0;
    wait_done("R5");
    swi_req = 1'b0;
    chk("R5", "busy first op", done_op, 3'd4);
    adopt();
    sp1 = ctx_sp;
    clear_logs();
    wait_done("R5");
    chk("R5", "late nmi op", done_op, 3'd2);
    chk_pushes("R5", sp1, 16'h5678, 16'h6666, 8'h07, 8'h08, 8'hD0);
    chk("R5", "late nmi sp", ctx_sp, sp1 - 16'd7);
    adopt();
    nmi_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_priority();
    set_snap(16'h7000, 16'h0100, 8'h11, 8'h22, 8'h00, 16'h01F0);
    irq_n = 1'b0;
    swi_req = 1'b1;
    wait_done("R7");
    chk("R7", "irq before swi", done_op, 3'd3);
    adopt();
    wait_done("R7");
    chk("R7", "swi after masked irq", done_op, 3'd4);
    swi_req = 1'b0;
    irq_n = 1'b1;
    snap_ccr = 8'h00;
    repeat (2) @(negedge clk);
    nmi_n = 1'b0;
    irq_n = 1'b0;
    wait_done("R7");
    chk("R7", "nmi before irq", done_op, 3'd2);
    adopt();
    irq_n = 1'b1;
    nmi_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_rti();
    set_snap(16'h0000, 16'h0000, 8'h00, 8'h00, 8'h10, 16'h0180);
    stk[8'h81] = 8'h05; stk[8'h82] = 8'h22; stk[8'h83] = 8'h11;
    stk[8'h84] = 8'h44; stk[8'h85] = 8'h33; stk[8'h86] = 8'h66; stk[8'h87] = 8'h55;
    clear_logs();
    rti_req = 1'b1;
    wait_done("R8");
    rti_req = 1'b0;
    chk("R8", "rti done_op", done_op, 3'd6);
    chk("R8", "rti writes", wr_n, 0);
    chk("R8", "rti read count", rd_n, 7);
    for (int k = 0; k < 7; k++)
      chk("R8", $sformatf("pull %0d addr", k), rd_a[k], 16'h0181 + 16'(k));
    chk("R8", "rti pc", ctx_pc, 16'h6655);
    chk("R8", "rti x", ctx_x, 16'h4433);
    chk("R8", "rti a/b", {ctx_a, ctx_b}, {8'h11, 8'h22});
    chk("R8", "rti ccr", ctx_ccr, 8'hC5);
    chk("R8", "rti sp", ctx_sp, 16'h0187);
    adopt();
    @(negedge clk);
  endtask

  task automatic t_wai();
    bit parked = 1'b0;
    set_snap(16'h8899, 16'hAABB, 8'h5A, 8'hA5, 8'h01, 16'h01F0);
    clear_logs();
    wai_req = 1'b1;
    for (int i = 0; i < 100 && !parked; i++) begin
      @(negedge clk);
      if (wait_idle) parked = 1'b1;
    end
    wai_req = 1'b0;
    chk("R9", "wait_idle raised", parked, 1'b1);
    chk_pushes("R9", 16'h01F0, 16'h8899, 16'hAABB, 8'h5A, 8'hA5, 8'h01);
    clear_logs();
    repeat (10) @(negedge clk);
    chk("R9", "parked bus quiet", wr_n + rd_n, 0);
    chk("R9", "still parked", wait_idle, 1'b1);
    irq_n = 1'b0;
    wait_done("R9");
    chk("R9", "wake op", done_op, 3'd3);
    chk("R9", "wake writes", wr_n, 0);
    chk("R9", "wake reads", {rd_a[0], rd_a[1]}, {16'hFFF8, 16'hFFF9});
    chk("R9", "wake pc", ctx_pc, 16'h1234);
    chk("R9", "wake sp", ctx_sp, 16'h01E9);
    chk("R4", "wake ccr", ctx_ccr, 8'hD1);
    adopt();
    irq_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 256; k++) stk[k] = 8'h00;
    vrom[0] = 8'h12; vrom[1] = 8'h34; vrom[2] = 8'h56; vrom[3] = 8'h78;
    vrom[4] = 8'h9A; vrom[5] = 8'hBC; vrom[6] = 8'hDE; vrom[7] = 8'hF0;
    set_snap(16'h0000, 16'h0000, 8'h00, 8'h00, 8'h00, 16'h01F0);
    repeat (4) @(negedge clk);
    chk("R11", "done low in reset", done, 1'b0);
    chk("R10", "no beat in reset", mem_valid, 1'b0);
    clear_logs();
    rst_n = 1'b1;
    t_reset();
    t_swi(1'b0);
    t_swi(1'b1);
    t_irq_mask();
    t_nmi();
    t_nmi_during_swi();
    t_priority();
    t_rti();
    t_wai();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule